// File: doc/BRIEF.md
# Line Transfer FIFO Across Clock Domains

This block carries one scan line of converted pixel words from the acquisition clock domain to a processor clock domain. Storage is a dual-clock memory. The two pointers cross between the domains in Gray code through multi-flop synchronizers. The writer pushes words while the write side reports ready. Once a whole line has been written, the write side reports full and stops taking words. The reader then gets a one-cycle interrupt pulse and a level line-ready status.

The reader drains words on read requests. The read side reinitializes the buffer once two things are true: the reader has taken the last word of the line, and the interrupt for that line has been seen. Reinitialization is a four-phase request and acknowledge exchange between the domains that returns both pointers to zero. The write side holds writes off until the exchange has finished. The reader sees the buffer as empty for the whole exchange. Words of a line that is still being written may be read early. Such reads never start a reinitialization.

Top module: `line_xfer_fifo`

## Requirements
- R1: After reset, wr_full, rd_irq, rd_line_ready and rd_data are 0, wr_ready is 1 and rd_empty is 1.
- R2: Words written while wr_ready is high come out on rd_data in write order. Each word appears after the first rd_clk edge at which rd_en is high and rd_empty is low.
- R3: A write attempted while wr_ready is low is dropped. Its word never appears on rd_data.
- R4: After the rising wr_clk edge that accepts the LINE_LEN-th word of a line, wr_full is 1 and wr_ready is 0. They stay that way until reinitialization.
- R5: rd_irq is high for exactly one rd_clk cycle per completed line, and rd_line_ready is high while rd_irq is high.
- R6: A read attempted while rd_empty is high leaves rd_data unchanged and moves no data.
- R7: Once the LINE_LEN-th word has been read and the line's interrupt has been seen, the buffer reinitializes. Afterwards wr_full and rd_line_ready are 0, wr_ready is 1 and rd_empty is 1, and the next line starts from its own first word.
- R8: Words of a line that is not yet complete can be read before the line completes. This raises no interrupt and starts no reinitialization, so wr_ready stays 1.
- R9: After the last word of a line has been read, rd_empty stays high until new words of the next line are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Acquisition-side clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Pixel word to store |
| wr_ready | output | 1 | A write request is accepted on the next edge |
| wr_full | output | 1 | A complete line is held |
| rd_clk | input | 1 | Processor-side clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word taken by the last accepted read |
| rd_empty | output | 1 | Nothing to read, or reinitialization running |
| rd_irq | output | 1 | One-cycle pulse when a line completes |
| rd_line_ready | output | 1 | Synchronized line-complete status |

## Verification
The hardest state to reach is a line whose words are read while the same line is still being written. Here the read pointer chases a write pointer that arrives late through the synchronizer, and the reinitialization trigger must wait for both the final read and the interrupt, whichever of the two comes last. The bench runs with unrelated clock periods and a short line. It sweeps line number against write gaps, read gaps and read start policy, so that some lines are drained as they fill and others only after the interrupt. One line also has a partial early drain followed by idle cycles before it completes.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

   typedef enum logic [1:0] {
      RI_IDLE = 2'd0,
      RI_REQ  = 2'd1,
      RI_DROP = 2'd2
   } reinit_state_e;

   function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/lfb_sync.sv
module lfb_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/lfb_ram.sv
module lfb_ram #(
   parameter int DW      = 16,
   parameter int AW      = 10,
   parameter bit OUT_REG = 1'b1
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rd_clk,
   input  logic          rd_rst_n,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (OUT_REG) begin : g_reg_out
         logic [DW-1:0] q_r;
         always_ff @(posedge rd_clk or negedge rd_rst_n) begin
            if (!rd_rst_n) q_r <= '0;
            else if (re)   q_r <= mem[raddr];
         end
         assign rdata = q_r;
      end else begin : g_ahead_out
         assign rdata = mem[raddr];
      end
   endgenerate

endmodule

// File: rtl/lfb_wr_ctrl.sv
module lfb_wr_ctrl #(
   parameter int AW       = 10,
   parameter int LINE_LEN = 576
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        req_sync,
   input  logic [AW:0] rgray_sync,
   output logic [AW:0] wgray,
   output logic [AW-1:0] waddr,
   output logic        we,
   output logic        full,
   output logic        ready,
   output logic        ack
);
   import lfb_pkg::*;

   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;
   localparam logic [PW-1:0] LINE_END  = PW'(LINE_LEN);
   localparam logic [PW-1:0] DEPTH_CNT = PW'(DEPTH);

   logic [PW-1:0] wbin;
   logic [PW-1:0] wbin_nxt;
   logic [PW-1:0] rbin_seen;
   logic [PW-1:0] occupancy;
   logic          held;
   logic          start_reinit;

   assign rbin_seen    = PW'(gray_to_bin(32'(rgray_sync)));
   assign occupancy    = wbin - rbin_seen;
   assign wbin_nxt     = wbin + 1'b1;
   assign start_reinit = req_sync && !ack;

   assign ready = !held && !req_sync && !ack && (occupancy < DEPTH_CNT);
   assign we    = wr_en && ready;
   assign waddr = wbin[AW-1:0];
   assign full  = held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
         held  <= 1'b0;
         ack   <= 1'b0;
      end else if (start_reinit) begin
         wbin  <= '0;
         wgray <= '0;
         held  <= 1'b0;
         ack   <= 1'b1;
      end else if (!req_sync && ack) begin
         ack <= 1'b0;
      end else if (we) begin
         wbin  <= wbin_nxt;
         wgray <= PW'(bin_to_gray(32'(wbin_nxt)));
         if (wbin_nxt == LINE_END) held <= 1'b1;
      end
   end

   a_r3_blocked_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !start_reinit) |=> $stable(wbin));

   a_r4_full_at_line_end: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (wbin == LINE_END));

   a_r7_ptr_within_line: assert property (@(posedge clk) disable iff (!rst_n)
      wbin <= LINE_END);

   a_r2_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_sync && !ack) |-> (occupancy <= DEPTH_CNT));

endmodule

// File: rtl/lfb_rd_ctrl.sv
module lfb_rd_ctrl #(
   parameter int AW       = 10,
   parameter int LINE_LEN = 576
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rd_en,
   input  logic [AW:0] wgray_sync,
   input  logic        ack_sync,
   input  logic        full_sync,
   output logic [AW:0] rgray,
   output logic [AW-1:0] raddr,
   output logic        re,
   output logic        empty,
   output logic        irq,
   output logic        line_ready,
   output logic        req
);
   import lfb_pkg::*;

   localparam int PW = AW + 1;
   localparam logic [PW-1:0] LINE_END = PW'(LINE_LEN);

   reinit_state_e st;
   logic [PW-1:0] rbin;
   logic [PW-1:0] rbin_nxt;
   logic          empty_raw;
   logic          line_prev;
   logic          line_rise;
   logic          armed;

   assign empty_raw  = (rgray == wgray_sync);
   assign empty      = empty_raw || (st != RI_IDLE);
   assign re         = rd_en && !empty;
   assign raddr      = rbin[AW-1:0];
   assign rbin_nxt   = rbin + 1'b1;
   assign line_rise  = full_sync && !line_prev;
   assign line_ready = full_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RI_IDLE;
         rbin      <= '0;
         rgray     <= '0;
         req       <= 1'b0;
         armed     <= 1'b0;
         line_prev <= 1'b0;
         irq       <= 1'b0;
      end else begin
         line_prev <= full_sync;
         irq       <= line_rise;
         if (line_rise) armed <= 1'b1;
         case (st)
            RI_IDLE: begin
               if (re) begin
                  rbin  <= rbin_nxt;
                  rgray <= PW'(bin_to_gray(32'(rbin_nxt)));
               end else if (armed && empty_raw && (rbin == LINE_END)) begin
                  st    <= RI_REQ;
                  req   <= 1'b1;
                  armed <= 1'b0;
               end
            end
            RI_REQ: begin
               if (ack_sync) begin
                  rbin  <= '0;
                  rgray <= '0;
                  req   <= 1'b0;
                  st    <= RI_DROP;
               end
            end
            RI_DROP: begin
               if (!ack_sync) st <= RI_IDLE;
            end
            default: st <= RI_IDLE;
         endcase
      end
   end

   a_r5_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   a_r5_irq_with_status: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> line_ready);

   a_r6_empty_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && st == RI_IDLE) |=> $stable(rbin));

   a_r7_reinit_after_full_line: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> (rbin == LINE_END));

endmodule

// File: rtl/line_xfer_fifo.sv
module line_xfer_fifo #(
   parameter int DATA_W      = 16,
   parameter int DEPTH       = 1024,
   parameter int LINE_LEN    = 576,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic              wr_full,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_empty,
   output logic              rd_irq,
   output logic              rd_line_ready
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   generate
      if (DEPTH != (1 << AW) || DEPTH < 2) begin : g_bad_depth
         $error("line_xfer_fifo: DEPTH must be a power of two of at least 2");
      end
      if (LINE_LEN < 1 || LINE_LEN > DEPTH) begin : g_bad_line
         $error("line_xfer_fifo: LINE_LEN must lie in 1..DEPTH");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("line_xfer_fifo: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("line_xfer_fifo: DATA_W must be positive");
      end
   endgenerate

   logic [PW-1:0] wgray, rgray;
   logic [PW-1:0] wgray_sync, rgray_sync;
   logic          full_int, ack, req;
   logic          full_sync, ack_sync, req_sync;
   logic          we, re;
   logic [AW-1:0] waddr, raddr;

   lfb_wr_ctrl #(.AW(AW), .LINE_LEN(LINE_LEN)) u_wr (
      .clk       (wr_clk),
      .rst_n     (wr_rst_n),
      .wr_en     (wr_en),
      .req_sync  (req_sync),
      .rgray_sync(rgray_sync),
      .wgray     (wgray),
      .waddr     (waddr),
      .we        (we),
      .full      (full_int),
      .ready     (wr_ready),
      .ack       (ack)
   );

   lfb_sync #(.W(PW + 2), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk  (rd_clk),
      .rst_n(rd_rst_n),
      .d    ({ack, full_int, wgray}),
      .q    ({ack_sync, full_sync, wgray_sync})
   );

   lfb_sync #(.W(PW + 1), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk  (wr_clk),
      .rst_n(wr_rst_n),
      .d    ({req, rgray}),
      .q    ({req_sync, rgray_sync})
   );

   lfb_rd_ctrl #(.AW(AW), .LINE_LEN(LINE_LEN)) u_rd (
      .clk       (rd_clk),
      .rst_n     (rd_rst_n),
      .rd_en     (rd_en),
      .wgray_sync(wgray_sync),
      .ack_sync  (ack_sync),
      .full_sync (full_sync),
      .rgray     (rgray),
      .raddr     (raddr),
      .re        (re),
      .empty     (rd_empty),
      .irq       (rd_irq),
      .line_ready(rd_line_ready),
      .req       (req)
   );

   lfb_ram #(.DW(DATA_W), .AW(AW), .OUT_REG(OUT_REG)) u_ram (
      .wr_clk  (wr_clk),
      .we      (we),
      .waddr   (waddr),
      .wdata   (wr_data),
      .rd_clk  (rd_clk),
      .rd_rst_n(rd_rst_n),
      .re      (re),
      .raddr   (raddr),
      .rdata   (rd_data)
   );

   assign wr_full = full_int;

   a_r4_full_blocks_ready: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      wr_full |-> !wr_ready);

endmodule

// File: tb/tb_line_xfer_fifo.sv
module tb_line_xfer_fifo;

   localparam int DW    = 16;
   localparam int DEPTH = 16;
   localparam int LLEN  = 12;
   localparam int NLINE = 6;

   logic          wr_clk = 1'b0, rd_clk = 1'b0;
   logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          wr_ready, wr_full, rd_empty, rd_irq, rd_line_ready;

   int checks = 0;
   int fails  = 0;
   int irq_count = 0;
   logic irq_prev = 1'b0;
   bit   done = 1'b0;

   always #4 wr_clk = ~wr_clk;
   always #5.5 rd_clk = ~rd_clk;

   line_xfer_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .LINE_LEN(LLEN)) dut (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_ready(wr_ready), .wr_full(wr_full),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
      .rd_empty(rd_empty), .rd_irq(rd_irq), .rd_line_ready(rd_line_ready)
   );

   function automatic logic [DW-1:0] pix(input int line, input int i);
      return DW'((line * 97 + i * 13 + 5) ^ (i << 9));
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // R5: count pulses and check their width
   always @(negedge rd_clk) begin
      if (rd_rst_n) begin
         if (rd_irq) begin
            irq_count++;
            chk(rd_line_ready, "R5 status with irq", int'(rd_line_ready), 1);
         end
         if (rd_irq && irq_prev) chk(1'b0, "R5 irq width", 2, 1);
         irq_prev = rd_irq;
      end
   end

   task automatic write_words(input int line, input int from, input int upto);
      int i = from;
      int c = 0;
      while (i < upto) begin
         @(negedge wr_clk);
         wr_en = 1'b0;
         c++;
         if (!((line % 2 == 1) && ((c + line) % 3 == 0)) && wr_ready) begin
            wr_en   = 1'b1;
            wr_data = pix(line, i);
            i++;
         end
      end
      @(negedge wr_clk);
      wr_en = 1'b0;
      if (upto == LLEN) begin
         chk(wr_full == 1'b1 && wr_ready == 1'b0, "R4 full after last word",
             int'({wr_full, wr_ready}), 2);
         // R3: attempts while blocked must vanish
         for (int k = 0; k < 3; k++) begin
            wr_en   = 1'b1;
            wr_data = 16'hDEAD;
            @(negedge wr_clk);
         end
         wr_en = 1'b0;
      end
   endtask

   task automatic read_words(input int line, input int from, input int upto, input bit wait_line);
      int  i = from;
      int  idx = 0;
      int  c = 0;
      bit  pend = 1'b0;
      if (wait_line) begin
         while (!rd_line_ready) @(negedge rd_clk);
      end
      while (i < upto || pend) begin
         @(negedge rd_clk);
         if (pend) begin
            chk(rd_data == pix(line, idx), "R2 data order", int'(rd_data), int'(pix(line, idx)));
            if (idx == LLEN - 1)
               chk(rd_data != 16'hDEAD, "R3 blocked word absent", int'(rd_data), int'(pix(line, idx)));
            pend = 1'b0;
         end
         rd_en = 1'b0;
         c++;
         if (i < upto && !rd_empty && ((c + line) % 4 != 3)) begin
            rd_en = 1'b1;
            pend  = 1'b1;
            idx   = i;
            i++;
         end
      end
      rd_en = 1'b0;
   endtask

   task automatic stale_read(input string tag);
      logic [DW-1:0] held;
      @(negedge rd_clk);
      held = rd_data;
      for (int k = 0; k < 3; k++) begin
         rd_en = 1'b1;
         @(negedge rd_clk);
      end
      rd_en = 1'b0;
      chk(rd_data == held, tag, int'(rd_data), int'(held));
   endtask

   initial begin
      int t;
      repeat (5) @(negedge wr_clk);
      wr_rst_n = 1'b1;
      @(negedge rd_clk);
      rd_rst_n = 1'b1;
      @(negedge rd_clk);
      chk(rd_empty && !rd_irq && !rd_line_ready && rd_data == '0, "R1 read side reset",
          int'({rd_empty, rd_irq, rd_line_ready}), 4);
      @(negedge wr_clk);
      chk(wr_ready && !wr_full, "R1 write side reset", int'({wr_ready, wr_full}), 2);
      stale_read("R6 read while empty after reset");
      chk(rd_empty == 1'b1, "R6 still empty", int'(rd_empty), 1);

      for (int line = 0; line < NLINE; line++) begin
         int pre;
         pre = (line == 0) ? 5 : 0;
         if (pre > 0) begin
            write_words(line, 0, pre);
            read_words(line, 0, pre, 1'b0);
            repeat (12) @(negedge rd_clk);
            chk(rd_empty && irq_count == 0 && !rd_line_ready, "R8 no line event on partial drain",
                irq_count, 0);
            @(negedge wr_clk);
            chk(wr_ready == 1'b1, "R8 writer not held", int'(wr_ready), 1);
         end
         fork
            write_words(line, pre, LLEN);
            read_words(line, pre, LLEN, (line % 3) != 2);
         join
         // R9: nothing readable once the line is drained
         for (int k = 0; k < 8; k++) begin
            @(negedge rd_clk);
            chk(rd_empty == 1'b1, "R9 empty after drain", int'(rd_empty), 1);
         end
         t = 0;
         while (!wr_ready && t < 200) begin
            @(negedge wr_clk);
            t++;
         end
         chk(wr_ready && !wr_full, "R7 writer released", int'({wr_ready, wr_full}), 2);
         @(negedge rd_clk);
         chk(!rd_line_ready && rd_empty, "R7 read side cleared",
             int'({rd_line_ready, rd_empty}), 1);
         chk(irq_count == line + 1, "R5 one irq per line", irq_count, line + 1);
         stale_read("R6 read while empty after line");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge wr_clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule